// File: doc/BRIEF.md
# Regulator Power-State Supervisor

This block is the digital supervisor of a chip that carries several voltage regulators. It samples a hardware enable pin, a software enable bit, supply comparator flags, a thermal flag and one power-good flag per regulator. From these it runs a state machine through internal reset, standby, startup sequencing and normal operation.

During startup the regulators are switched on one at a time, in index order. A fixed number of clock cycles separates each step. The machine enters normal operation only once every regulator is on and all of them report power good. If that does not happen within a timeout, the machine returns to standby and raises a fault bit.

The block also drives a shutdown-release line for a downstream device. In that decision the hardware pin takes priority over a software force bit. A small register file, reached through a plain write port and a combinational read port, holds its contents across an undervoltage event. The register file is cleared only when the supply drops below the power-on-reset level.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After `rst_ni` is released, `state_o` is 0 (internal reset), `reg_en_o` is 0, `shdn_rel_o` is 0 and every register reads 0. With the supply above the reset level (`por_ok_i`=1), the state moves to 1 (standby).
- R2: While `por_ok_i` is 0, the state is 0, all regulator enables are 0 and all writable register bits are cleared. When the supply returns, the state goes to standby and does not start again until the host rewrites the enable bit.
- R3: With `uvlo_i` high, the state leaves sequencing (2) or normal operation (3) for standby (1), and every enable is cleared at once. Register contents are kept. No start happens while `uvlo_i` stays high.
- R4: From standby, the sequence starts (state 2) when the enable pin is high or bit 0 of the enable register at address 0x01 is set.
- R5: In state 2, regulator 0 is on first. One more regulator is added, in index order, every STEP_CYCLES clock cycles.
- R6: State 3 is entered only when all regulators are enabled and all power-good flags are high. It is not entered while any flag is low.
- R7: With the enable pin low and the software enable bit clear, states 2 and 3 return to standby and all enables go to 0.
- R8: A thermal flag in state 3 moves the state to 4 and clears all enables. When the flag falls, the state returns to standby.
- R9: If state 3 is not reached within TIMEOUT_CYCLES of the start, the state returns to standby and fault bit 4 of address 0x03 is set. The state stays in standby until the enable request is withdrawn, which clears the fault bit.
- R10: `shdn_rel_o` is 0 when the enable pin is low and the software enable bit is 0.
- R11: When the enable pin is low and the software enable bit is 1, `shdn_rel_o` equals (all power-good flags high) AND (force bit 0 of address 0x03).
- R12: When the enable pin is high, `shdn_rel_o` equals "all power-good flags high", whatever the software bits are.
- R13: Bits 3:1 of address 0x03 read the synchronised power-good flags of regulators 0 to 2. Writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_pin_i | input | 1 | Hardware enable pin (asynchronous) |
| por_ok_i | input | 1 | Supply above power-on-reset level (asynchronous) |
| uvlo_i | input | 1 | Supply below undervoltage-falling level (asynchronous) |
| tsd_i | input | 1 | Thermal shutdown flag (asynchronous) |
| pgood_i | input | N_REG | Per-regulator power-good flags (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| reg_en_o | output | N_REG | Regulator enables |
| shdn_rel_o | output | 1 | Shutdown-release output to external device |
| state_o | output | 3 | Encoded state: 0 reset, 1 standby, 2 sequencing, 3 normal, 4 thermal |

## Verification
The bench separates the two supply faults. After an undervoltage it reads the force and enable bits back and expects them to survive. After a supply-reset loss it expects them to be gone. A design that merged the two paths would either lose its configuration after a brief dip or restart on stale settings.

The bench holds one power-good flag low after every regulator is on, which catches a design that enters normal operation before all flags are high. It also lets the timeout expire with the enable pin still high. A design without the fault lock would then cycle through restarts.

Random combinations of pin, software enable, force bit and power-good flags probe the priority of the release output. A design that let the force bit override the pin would drive the wrong level.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_STANDBY = 3'd1,
    ST_SEQ     = 3'd2,
    ST_NORMAL  = 3'd3,
    ST_THERMAL = 3'd4
  } pwr_state_e;

  localparam int unsigned DATA_W = 8;
  localparam logic [7:0] ADDR_ENABLE = 8'h01;
  localparam logic [7:0] ADDR_CTRL   = 8'h03;
  localparam int unsigned FORCE_BIT  = 0;
  localparam int unsigned PG_LSB     = 1;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_REG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [7:0]        rd_addr_i,
  input  logic [N_REG-1:0]  pg_i,
  input  logic              fault_i,
  output logic              sw_en_o,
  output logic              force_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned FAULT_BIT = PG_LSB + N_REG;

  logic sw_en_q, force_q;
  logic unused_wdata;
  assign unused_wdata = ^wr_data_i[DATA_W-1:1];

  // supply-reset loss clears; undervoltage does not reach here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_q <= 1'b0;
      force_q <= 1'b0;
    end else if (clr_i) begin
      sw_en_q <= 1'b0;
      force_q <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_ENABLE) sw_en_q <= wr_data_i[0];
      if (wr_addr_i == ADDR_CTRL)   force_q <= wr_data_i[FORCE_BIT];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_ENABLE) begin
      rd_data_o[0] = sw_en_q;
    end else if (rd_addr_i == ADDR_CTRL) begin
      rd_data_o[FORCE_BIT]                = force_q;
      rd_data_o[PG_LSB +: N_REG]          = pg_i;
      rd_data_o[FAULT_BIT]                = fault_i;
    end
  end

  assign sw_en_o = sw_en_q;
  assign force_o = force_q;
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_REG          = 3,
  parameter int unsigned STEP_CYCLES    = 250000,
  parameter int unsigned TIMEOUT_CYCLES = 1000000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_s_i,
  input  logic             uvlo_s_i,
  input  logic             tsd_s_i,
  input  logic             req_i,
  input  logic             pg_all_i,
  output pwr_state_e       state_o,
  output logic [N_REG-1:0] reg_en_o,
  output logic             fault_o
);
  localparam int unsigned STEP_W = $clog2(STEP_CYCLES + 1);
  localparam int unsigned TO_W   = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_CYCLES - 1);

  pwr_state_e        state_q;
  logic [N_REG-1:0]  en_q;
  logic [STEP_W-1:0] step_q;
  logic [TO_W-1:0]   to_q;
  logic              fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      en_q    <= '0;
      step_q  <= '0;
      to_q    <= '0;
      fault_q <= 1'b0;
    end else if (!por_s_i) begin
      state_q <= ST_RESET;
      en_q    <= '0;
      step_q  <= '0;
      to_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RESET: state_q <= ST_STANDBY;
        ST_STANDBY: begin
          if (!req_i) fault_q <= 1'b0;
          else if (!fault_q && !uvlo_s_i) begin
            state_q <= ST_SEQ;
            en_q    <= N_REG'(1);
            step_q  <= '0;
            to_q    <= '0;
          end
        end
        ST_SEQ: begin
          if (!req_i || uvlo_s_i) begin
            state_q <= ST_STANDBY;
            en_q    <= '0;
          end else if (&en_q && pg_all_i) begin
            state_q <= ST_NORMAL;
          end else if (to_q == TO_LAST) begin
            state_q <= ST_STANDBY;
            en_q    <= '0;
            fault_q <= 1'b1;
          end else begin
            to_q <= to_q + 1'b1;
            if (!(&en_q)) begin
              if (step_q == STEP_LAST) begin
                step_q <= '0;
                en_q   <= {en_q[N_REG-2:0], 1'b1};
              end else begin
                step_q <= step_q + 1'b1;
              end
            end
          end
        end
        ST_NORMAL: begin
          if (!req_i || uvlo_s_i) begin
            state_q <= ST_STANDBY;
            en_q    <= '0;
          end else if (tsd_s_i) begin
            state_q <= ST_THERMAL;
            en_q    <= '0;
          end
        end
        ST_THERMAL: if (!tsd_s_i) state_q <= ST_STANDBY;
        default: begin
          state_q <= ST_STANDBY;
          en_q    <= '0;
        end
      endcase
    end
  end

  assign state_o  = state_q;
  assign reg_en_o = en_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_REG          = 3,
  parameter int unsigned STEP_CYCLES    = 250000,
  parameter int unsigned TIMEOUT_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_pin_i,
  input  logic              por_ok_i,
  input  logic              uvlo_i,
  input  logic              tsd_i,
  input  logic [N_REG-1:0]  pgood_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [N_REG-1:0]  reg_en_o,
  output logic              shdn_rel_o,
  output logic [2:0]        state_o
);
  localparam int unsigned SYNC_W = N_REG + 4;

  logic [SYNC_W-1:0] sync_q;
  logic              en_s, por_s, uvlo_s, tsd_s;
  logic [N_REG-1:0]  pg_s;
  logic              pg_all, sw_en, force_xs, fault, rel_q;
  pwr_state_e        state;

  pwr_sync #(.W(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pgood_i, tsd_i, uvlo_i, por_ok_i, en_pin_i}),
    .q_o    (sync_q)
  );

  assign en_s   = sync_q[0];
  assign por_s  = sync_q[1];
  assign uvlo_s = sync_q[2];
  assign tsd_s  = sync_q[3];
  assign pg_s   = sync_q[4 +: N_REG];
  assign pg_all = &pg_s;

  pwr_regs #(.N_REG(N_REG)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!por_s),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .pg_i      (pg_s),
    .fault_i   (fault),
    .sw_en_o   (sw_en),
    .force_o   (force_xs),
    .rd_data_o (rd_data_o)
  );

  pwr_fsm #(
    .N_REG          (N_REG),
    .STEP_CYCLES    (STEP_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .por_s_i  (por_s),
    .uvlo_s_i (uvlo_s),
    .tsd_s_i  (tsd_s),
    .req_i    (en_s | sw_en),
    .pg_all_i (pg_all),
    .state_o  (state),
    .reg_en_o (reg_en_o),
    .fault_o  (fault)
  );

  // pin has priority over the software force bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= 1'b0;
    else if (en_s) rel_q <= pg_all;
    else rel_q <= sw_en & force_xs & pg_all;
  end

  assign shdn_rel_o = rel_q;
  assign state_o    = state;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
  parameter int unsigned N_REG = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       state_i,
  input logic [N_REG-1:0] reg_en_i,
  input logic             rel_i,
  input logic             en_s_i,
  input logic             por_s_i,
  input logic             uvlo_s_i,
  input logic             tsd_s_i,
  input logic             pg_all_i,
  input logic             sw_en_i,
  input logic             force_i,
  input logic             fault_i
);
  assert_por_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0) |-> (!sw_en_i && !force_i && reg_en_i == '0));

  assert_uvlo_standby_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_s_i && uvlo_s_i && (state_i == 3'd2 || state_i == 3'd3))
      |=> (state_i == 3'd1 && reg_en_i == '0));

  assert_seq_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd2) |-> (reg_en_i != '0 && ((reg_en_i & (reg_en_i + 1'b1)) == '0)));

  assert_normal_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd3 && $past(state_i) == 3'd2) |-> ($past(pg_all_i) && &reg_en_i));

  assert_thermal_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_s_i && tsd_s_i && !uvlo_s_i && en_s_i && state_i == 3'd3)
      |=> (state_i == 3'd4 && reg_en_i == '0));

  assert_fault_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_s_i && state_i == 3'd1 && fault_i) |=> (state_i != 3'd2));

  assert_rel_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s_i && !sw_en_i) |=> !rel_i);

  assert_rel_force_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s_i && sw_en_i && !force_i) |=> !rel_i);

  assert_rel_pin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s_i |=> (rel_i == $past(pg_all_i)));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.N_REG(N_REG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state_o),
  .reg_en_i (reg_en_o),
  .rel_i    (shdn_rel_o),
  .en_s_i   (en_s),
  .por_s_i  (por_s),
  .uvlo_s_i (uvlo_s),
  .tsd_s_i  (tsd_s),
  .pg_all_i (pg_all),
  .sw_en_i  (sw_en),
  .force_i  (force_xs),
  .fault_i  (fault)
);

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
  localparam int unsigned N_REG = 3;
  localparam int unsigned STEP  = 16;
  localparam int unsigned TOUT  = 80;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_pin_i = 1'b0, por_ok_i = 1'b1, uvlo_i = 1'b0, tsd_i = 1'b0;
  logic [2:0] pgood_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_addr_i = '0, wr_data_i = '0, rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [2:0] reg_en_o;
  logic       shdn_rel_o;
  logic [2:0] state_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk_i = ~clk_i;

  pwr_seq_ctrl #(.N_REG(N_REG), .STEP_CYCLES(STEP), .TIMEOUT_CYCLES(TOUT)) dut_i (
    .clk_i, .rst_ni, .en_pin_i, .por_ok_i, .uvlo_i, .tsd_i, .pgood_i,
    .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .reg_en_o, .shdn_rel_o, .state_o
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_rel(logic pin, logic sw, logic frc, logic [2:0] pg);
    if (pin) return &pg;
    return sw & frc & (&pg);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    tick(3);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 reg_en", reg_en_o, 0);
    check("R1 rel", shdn_rel_o, 0);
    rd(8'h01, d); check("R1 enable reg", d, 0);
    tick(5);
    check("R1 standby", state_o, 1);

    // R4/R5 start by pin, ordered enables
    en_pin_i = 1'b1;
    tick(10);
    check("R4 seq", state_o, 2);
    check("R5 step0", reg_en_o, 1);
    tick(16);
    check("R5 step1", reg_en_o, 3);
    tick(16);
    check("R5 step2", reg_en_o, 7);
    // R6 one flag low keeps sequencing
    pgood_i = 3'b011;
    tick(6);
    check("R6 not normal", state_o, 2);
    pgood_i = 3'b111;
    tick(5);
    check("R6 normal", state_o, 3);
    check("R12 rel pin", shdn_rel_o, 1);
    rd(8'h03, d); check("R13 pg field", d[3:1], 7);

    // R7 pin off
    en_pin_i = 1'b0;
    tick(5);
    check("R7 standby", state_o, 1);
    check("R7 reg_en", reg_en_o, 0);
    check("R10 rel", shdn_rel_o, 0);

    // R4 software start
    wr(8'h01, 8'h01);
    tick(3);
    check("R4 sw seq", state_o, 2);
    tick(40);
    check("R4 sw normal", state_o, 3);

    // R3 undervoltage keeps registers
    wr(8'h03, 8'h0F);
    uvlo_i = 1'b1;
    tick(5);
    check("R3 standby", state_o, 1);
    check("R3 reg_en", reg_en_o, 0);
    rd(8'h03, d); check("R3 force kept", d[0], 1);
    rd(8'h01, d); check("R3 sw_en kept", d[0], 1);
    tick(10);
    check("R3 no start", state_o, 1);
    uvlo_i = 1'b0;
    tick(45);
    check("R3 restart", state_o, 3);

    // R8 thermal
    tsd_i = 1'b1;
    tick(5);
    check("R8 thermal", state_o, 4);
    check("R8 reg_en", reg_en_o, 0);
    tsd_i = 1'b0;
    tick(5);
    check("R8 left", state_o != 4, 1);
    tick(40);
    check("R8 back normal", state_o, 3);

    // R7 software off
    wr(8'h01, 8'h00);
    tick(3);
    check("R7 sw off", state_o, 1);

    // R9 timeout and fault lock
    pgood_i = 3'b000;
    en_pin_i = 1'b1;
    tick(100);
    check("R9 standby", state_o, 1);
    check("R9 reg_en", reg_en_o, 0);
    rd(8'h03, d); check("R9 fault set", d[4], 1);
    tick(20);
    check("R9 locked", state_o, 1);
    en_pin_i = 1'b0;
    tick(5);
    rd(8'h03, d); check("R9 fault clear", d[4], 0);

    // R2 supply-reset loss
    pgood_i = 3'b111;
    wr(8'h01, 8'h01);
    wr(8'h03, 8'h01);
    tick(40);
    check("R2 pre normal", state_o, 3);
    por_ok_i = 1'b0;
    tick(4);
    check("R2 reset", state_o, 0);
    check("R2 reg_en", reg_en_o, 0);
    rd(8'h01, d); check("R2 sw_en clr", d[0], 0);
    rd(8'h03, d); check("R2 force clr", d[0], 0);
    tick(10);
    check("R2 held", state_o, 0);
    por_ok_i = 1'b1;
    tick(5);
    check("R2 standby", state_o, 1);
    tick(10);
    check("R2 no auto start", state_o, 1);

    // R10/R11/R12/R13 random release-output cases
    for (int i = 0; i < 60; i++) begin
      logic pin, sw, frc;
      logic [2:0] pg;
      pin = 1'($urandom % 2);
      sw  = 1'($urandom % 2);
      frc = 1'($urandom % 2);
      pg  = (($urandom % 3) == 0) ? 3'b111 : 3'($urandom % 8);
      wr(8'h01, {7'd0, sw});
      wr(8'h03, {7'd0, frc});
      en_pin_i = pin;
      pgood_i  = pg;
      tick(5);
      if (pin)     check("R12 rel", shdn_rel_o, exp_rel(pin, sw, frc, pg));
      else if (sw) check("R11 rel", shdn_rel_o, exp_rel(pin, sw, frc, pg));
      else         check("R10 rel", shdn_rel_o, exp_rel(pin, sw, frc, pg));
      rd(8'h03, d);
      check("R13 pg read", d[3:1], pg);
    end
    // R13 writes to read-only field ignored
    pgood_i = 3'b010;
    wr(8'h03, 8'h0E);
    tick(4);
    rd(8'h03, d); check("R13 ro", d[3:1], 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule